// File: doc/BRIEF.md
# Serial Flash Busy-Status Poller

This block waits for a serial flash device to finish an internal operation. It runs one or more poll frames. In each frame it lowers chip select, shifts out a status-read opcode, turns the data lanes around and reads back one status byte. It then tests the busy flag in that byte. While the flag is set, it releases chip select for a short fixed gap and runs the next frame. When the flag is clear, it stops and pulses a done strobe.

A 32-bit configuration word is written before the poll starts. It gives the opcode, the opcode length (one or two bytes), the lane width (one, two or four data lines) and the bit of the status byte that holds the busy flag. With these settings one engine can serve flash parts that follow different status conventions. The serial clock is a fixed division of the system clock: it idles low, the block changes data while it is low, and both sides sample on its rising edge.

Top module: `flash_busy_poller`

## Requirements
- R1: Configuration word layout is: opcode in bits 15:0, length code in bits 17:16, lane code in bits 19:18, busy position in bit 20. It resets to zero, and bits 31:21 always read back as zero.
- R2: When start arrives with a reserved lane code (11) or a reserved length code (00 or 11), chip select stays high and cfg_err is set. The all-zero reset configuration is one such case. cfg_err clears when a later start is accepted.
- R3: A length code of 10 sends opcode bits 15:8 and then bits 7:0. A length code of 01 sends only bits 7:0. Every byte goes out most significant bit first.
- R4: Lane code 00 moves one bit per serial clock: it drives lane 0 and samples lane 1. Code 01 moves two bits on lanes 1:0, and code 10 moves four bits on lanes 3:0. In both of these modes lane 0 carries the least significant bit of each group.
- R5: Data output enables are 0001, 0011 or 1111 for codes 00, 01 and 10 while the opcode is sent. They are 0000 during turnaround and readback, and whenever chip select is high.
- R6: In the two- and four-lane modes, exactly one serial clock without sampling falls between the opcode and the status byte. In single-lane mode there is none.
- R7: Each frame holds chip select low for exactly the opcode clocks, any turnaround clock and one status byte. Between frames of the same poll, chip select stays high for exactly GAP_CLKS system clocks, and the serial clock is low whenever chip select is high.
- R8: Position bit 1 selects status bit 7 as the busy flag; position bit 0 selects status bit 0.
- R9: A set busy flag starts another frame. A clear flag ends the poll, and done goes high for exactly one cycle. No further frame follows.
- R10: A start pulse that arrives while a poll is running has no effect. polling is high from acceptance until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| start | input | 1 | Begin a poll |
| polling | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse when the busy flag reads clear |
| cfg_err | output | 1 | Last start was refused for a reserved encoding |
| sq_cs_n | output | 1 | Flash chip select, active low |
| sq_sck | output | 1 | Serial clock |
| sq_dout | output | 4 | Data lane outputs |
| sq_oe | output | 4 | Per-lane output enables |
| sq_din | input | 4 | Data lane inputs |

## Verification
The hardest case to reach is a poll that runs many frames. In such a poll the busy bit, the lane order and the turnaround all have to line up on every readback, and a start request can arrive in the middle of a frame. The bench uses a pin-level flash model that answers with a set busy flag for a chosen number of frames. Only after that does it return a byte whose busy bit is clear while the other candidate bit stays set. The model counts rising serial clocks to decide when to drive each status group. A second start is pushed in during a frame, so a wrongly accepted start would show up as an extra done strobe or a wrong frame count.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   localparam int OP_BITS   = 16;
   localparam int STAT_BITS = 8;
   localparam int NUM_LANES = 4;
   localparam int SLOT_W    = $clog2(OP_BITS + 1);

   localparam logic [1:0] LEN_ONE = 2'b01;
   localparam logic [1:0] LEN_TWO = 2'b10;

   typedef logic [SLOT_W-1:0] slot_t;

   typedef enum logic [1:0] {
      LANE_X1  = 2'b00,
      LANE_X2  = 2'b01,
      LANE_X4  = 2'b10,
      LANE_RSV = 2'b11
   } lane_mode_e;

   // Field order is significant: it places each field at its bit position.
   typedef struct packed {
      logic                busy_hi;
      lane_mode_e          lanes;
      logic [1:0]          op_len;
      logic [OP_BITS-1:0]  opcode;
   } poll_cfg_t;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_CMD,
      SQ_TURN,
      SQ_READ,
      SQ_GAP
   } seq_state_e;

   function automatic logic cfg_legal(poll_cfg_t c);
      return (c.lanes != LANE_RSV) && ((c.op_len == LEN_ONE) || (c.op_len == LEN_TWO));
   endfunction

   function automatic slot_t cmd_slots(poll_cfg_t c);
      slot_t nbits;
      nbits = (c.op_len == LEN_TWO) ? slot_t'(OP_BITS) : slot_t'(OP_BITS / 2);
      case (c.lanes)
         LANE_X2: return nbits >> 1;
         LANE_X4: return nbits >> 2;
         default: return nbits;
      endcase
   endfunction

   function automatic slot_t read_slots(lane_mode_e m);
      case (m)
         LANE_X2: return slot_t'(STAT_BITS / 2);
         LANE_X4: return slot_t'(STAT_BITS / 4);
         default: return slot_t'(STAT_BITS);
      endcase
   endfunction

   function automatic logic [OP_BITS-1:0] frame_word(poll_cfg_t c);
      return (c.op_len == LEN_TWO) ? c.opcode : {c.opcode[OP_BITS/2-1:0], {(OP_BITS/2){1'b0}}};
   endfunction

endpackage

// File: rtl/fbp_cfg_reg.sv
module fbp_cfg_reg
   import fbp_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output poll_cfg_t         cfg,
   output logic [WORD_W-1:0] rd_data
);

   localparam int CFG_W = $bits(poll_cfg_t);

   if (WORD_W < CFG_W) begin : g_bad_width
      $error("fbp_cfg_reg: WORD_W too narrow for the configuration fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr_en) begin
         cfg <= poll_cfg_t'(wr_data[CFG_W-1:0]);
      end
   end

   always_comb begin
      rd_data              = '0;
      rd_data[CFG_W-1:0]   = cfg;
   end

endmodule

// File: rtl/fbp_lane_shift.sv
module fbp_lane_shift
   import fbp_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [OP_BITS-1:0]    load_word,
   input  logic                  shift_tx,
   input  logic                  sample_rx,
   input  logic                  oe_en,
   input  lane_mode_e            mode,
   input  logic [NUM_LANES-1:0]  din,
   output logic [NUM_LANES-1:0]  dout,
   output logic [NUM_LANES-1:0]  oe,
   output logic [STAT_BITS-1:0]  rx_byte
);

   logic [OP_BITS-1:0]   sh;
   logic [STAT_BITS-1:0] rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (load) begin
         sh <= load_word;
      end else if (shift_tx) begin
         case (mode)
            LANE_X2: sh <= sh << 2;
            LANE_X4: sh <= sh << 4;
            default: sh <= sh << 1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx <= '0;
      end else if (sample_rx) begin
         case (mode)
            LANE_X2: rx <= {rx[STAT_BITS-3:0], din[1:0]};
            LANE_X4: rx <= {rx[STAT_BITS-5:0], din[3:0]};
            default: rx <= {rx[STAT_BITS-2:0], din[1]};
         endcase
      end
   end

   // Per-lane output selection: the top bits of the shift register form the
   // current group, with lane 0 taking the group's least significant bit.
   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      if (l == 0) begin : g_l0
         assign dout[l] = (mode == LANE_X1) ? sh[OP_BITS-1] :
                          (mode == LANE_X2) ? sh[OP_BITS-2] : sh[OP_BITS-4];
         assign oe[l]   = oe_en;
      end else if (l == 1) begin : g_l1
         assign dout[l] = (mode == LANE_X1) ? 1'b0 :
                          (mode == LANE_X2) ? sh[OP_BITS-1] : sh[OP_BITS-3];
         assign oe[l]   = oe_en && (mode != LANE_X1);
      end else begin : g_lhi
         assign dout[l] = (mode == LANE_X4) ? sh[OP_BITS-4+l] : 1'b0;
         assign oe[l]   = oe_en && (mode == LANE_X4);
      end
   end

   assign rx_byte = rx;

endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
   import fbp_pkg::*;
#(
   parameter int SCK_HALF = 2,
   parameter int GAP_CLKS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  poll_cfg_t            cfg,
   input  logic [STAT_BITS-1:0] rx_byte,
   output logic                 cs_n,
   output logic                 sck,
   output logic                 load,
   output logic [OP_BITS-1:0]   load_word,
   output logic                 shift_tx,
   output logic                 sample_rx,
   output logic                 oe_en,
   output lane_mode_e           mode,
   output logic                 active,
   output logic                 done,
   output logic                 err
);

   localparam int PH_MAX = 2 * SCK_HALF - 1;
   localparam int PH_W   = (PH_MAX < 1) ? 1 : $clog2(PH_MAX + 1);
   localparam int GAP_W  = $clog2(GAP_CLKS + 1);

   if (SCK_HALF < 1) begin : g_bad_half
      $error("fbp_seq: SCK_HALF must be at least 1");
   end
   if (GAP_CLKS < 2) begin : g_bad_gap
      $error("fbp_seq: GAP_CLKS must be at least 2");
   end

   seq_state_e        state;
   logic [PH_W-1:0]   ph;
   slot_t             slot;
   slot_t             last_slot;
   logic [GAP_W-1:0]  gap;
   poll_cfg_t         snap;
   logic              done_q;
   logic              err_q;

   logic in_slot, slot_end, rise_now, gap_end, busy_bit, accept;

   assign in_slot  = (state == SQ_CMD) || (state == SQ_TURN) || (state == SQ_READ);
   assign slot_end = (ph == PH_W'(PH_MAX));
   assign rise_now = (ph == PH_W'(SCK_HALF));
   assign gap_end  = (state == SQ_GAP) && (gap == GAP_W'(GAP_CLKS - 1));
   assign busy_bit = snap.busy_hi ? rx_byte[STAT_BITS-1] : rx_byte[0];
   assign accept   = (state == SQ_IDLE) && start && cfg_legal(cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         ph        <= '0;
         slot      <= '0;
         last_slot <= '0;
         gap       <= '0;
         snap      <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  if (cfg_legal(cfg)) begin
                     snap      <= cfg;
                     err_q     <= 1'b0;
                     state     <= SQ_CMD;
                     ph        <= '0;
                     slot      <= '0;
                     last_slot <= cmd_slots(cfg) - 1'b1;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            SQ_CMD, SQ_TURN, SQ_READ: begin
               if (slot_end) begin
                  ph <= '0;
                  if (slot == last_slot) begin
                     slot <= '0;
                     case (state)
                        SQ_CMD: begin
                           if (snap.lanes == LANE_X1) begin
                              state     <= SQ_READ;
                              last_slot <= read_slots(snap.lanes) - 1'b1;
                           end else begin
                              state     <= SQ_TURN;
                              last_slot <= '0;
                           end
                        end
                        SQ_TURN: begin
                           state     <= SQ_READ;
                           last_slot <= read_slots(snap.lanes) - 1'b1;
                        end
                        default: begin
                           state <= SQ_GAP;
                           gap   <= '0;
                        end
                     endcase
                  end else begin
                     slot <= slot + 1'b1;
                  end
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            SQ_GAP: begin
               if (gap == GAP_W'(GAP_CLKS - 1)) begin
                  if (busy_bit) begin
                     state     <= SQ_CMD;
                     ph        <= '0;
                     slot      <= '0;
                     last_slot <= cmd_slots(snap) - 1'b1;
                  end else begin
                     state  <= SQ_IDLE;
                     done_q <= 1'b1;
                  end
               end else begin
                  gap <= gap + 1'b1;
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign cs_n      = !in_slot;
   assign sck       = in_slot && (ph >= PH_W'(SCK_HALF));
   assign load      = accept || (gap_end && busy_bit);
   assign load_word = (state == SQ_IDLE) ? frame_word(cfg) : frame_word(snap);
   assign shift_tx  = (state == SQ_CMD) && slot_end;
   assign sample_rx = (state == SQ_READ) && rise_now;
   assign oe_en     = (state == SQ_CMD);
   assign mode      = snap.lanes;
   assign active    = (state != SQ_IDLE);
   assign done      = done_q;
   assign err       = err_q;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);                                                // R9
   AST_ERR_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (state == SQ_IDLE));                                      // R2
   AST_BUSY_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (gap_end && busy_bit) |=> (state == SQ_CMD));                       // R9
   AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      (active && start && !gap_end) |=> $stable(snap));                   // R10

endmodule

// File: rtl/flash_busy_poller.sv
module flash_busy_poller
   import fbp_pkg::*;
#(
   parameter int CFG_W    = 32,
   parameter int SCK_HALF = 2,
   parameter int GAP_CLKS = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_rdata,
   input  logic                 start,
   output logic                 polling,
   output logic                 done,
   output logic                 cfg_err,
   output logic                 sq_cs_n,
   output logic                 sq_sck,
   output logic [NUM_LANES-1:0] sq_dout,
   output logic [NUM_LANES-1:0] sq_oe,
   input  logic [NUM_LANES-1:0] sq_din
);

   poll_cfg_t            cfg;
   logic                 load, shift_tx, sample_rx, oe_en;
   logic [OP_BITS-1:0]   load_word;
   logic [STAT_BITS-1:0] rx_byte;
   lane_mode_e           mode;

   fbp_cfg_reg #(.WORD_W(CFG_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .cfg     (cfg),
      .rd_data (cfg_rdata)
   );

   fbp_lane_shift u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (load_word),
      .shift_tx  (shift_tx),
      .sample_rx (sample_rx),
      .oe_en     (oe_en),
      .mode      (mode),
      .din       (sq_din),
      .dout      (sq_dout),
      .oe        (sq_oe),
      .rx_byte   (rx_byte)
   );

   fbp_seq #(.SCK_HALF(SCK_HALF), .GAP_CLKS(GAP_CLKS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cfg       (cfg),
      .rx_byte   (rx_byte),
      .cs_n      (sq_cs_n),
      .sck       (sq_sck),
      .load      (load),
      .load_word (load_word),
      .shift_tx  (shift_tx),
      .sample_rx (sample_rx),
      .oe_en     (oe_en),
      .mode      (mode),
      .active    (polling),
      .done      (done),
      .err       (cfg_err)
   );

   AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_oe != '0) |-> !sq_cs_n);                                        // R5
   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      sample_rx |-> (sq_oe == '0));                                       // R5
   AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sq_cs_n) |=> sq_cs_n);                                        // R7
   AST_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sq_cs_n |-> !sq_sck);                                               // R7
   AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sq_cs_n && !polling));                                    // R9
   AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> (sq_cs_n && (sq_oe == '0)));                            // R2

endmodule

// File: tb/tb_flash_busy_poller.sv
module tb_flash_busy_poller;
   import fbp_pkg::*;

   localparam int GAP = 3;
   localparam int WDOG = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        start = 1'b0;
   logic        polling, done, cfg_err, sq_cs_n, sq_sck;
   logic [3:0]  sq_dout, sq_oe;
   logic [3:0]  sq_din = '0;

   always #4 clk = ~clk;

   flash_busy_poller #(.CFG_W(32), .SCK_HALF(2), .GAP_CLKS(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .start(start), .polling(polling), .done(done),
      .cfg_err(cfg_err), .sq_cs_n(sq_cs_n), .sq_sck(sq_sck),
      .sq_dout(sq_dout), .sq_oe(sq_oe), .sq_din(sq_din)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] lane_mask(input int w);
      return (w == 1) ? 4'h1 : (w == 2) ? 4'h3 : 4'hF;
   endfunction

   // flash model state
   int          m_w = 1, m_cmd_bits = 8, m_busy = 0, frame_idx = 0, edge_cnt = 0;
   bit          m_pos = 1'b1;
   logic [15:0] m_op = '0;
   logic [15:0] cap = '0;
   bit          oe_bad = 1'b0;
   int          cs_falls = 0;

   typedef struct { logic [15:0] op; int frames; } exp_t;
   exp_t sb[$];

   always @(negedge sq_cs_n) begin
      edge_cnt = 0;
      cap      = '0;
      oe_bad   = 1'b0;
      cs_falls++;
   end

   always @(posedge sq_sck) begin
      int ce;
      ce = m_cmd_bits / m_w;
      if (edge_cnt < ce) begin
         for (int b = m_w - 1; b >= 0; b--) cap = {cap[14:0], sq_dout[b]};
         if (sq_oe != lane_mask(m_w)) oe_bad = 1'b1;
      end else if (sq_oe != 4'h0) begin
         oe_bad = 1'b1;
      end
      edge_cnt++;
   end

   always @(negedge sq_sck) begin
      int base, k;
      logic [7:0] sbyte;
      logic [3:0] g;
      base = m_cmd_bits / m_w + ((m_w > 1) ? 1 : 0);
      if (edge_cnt >= base && edge_cnt < base + 8 / m_w) begin
         k = edge_cnt - base;
         sbyte = (frame_idx < m_busy) ? 8'h81 : (m_pos ? 8'h7F : 8'hFE);
         g = 4'((sbyte >> (8 - (k + 1) * m_w)) & {4'h0, lane_mask(m_w)});
         if (m_w == 1) sq_din = {2'b00, g[0], ~g[0]};
         else          sq_din = g;
      end
   end

   always @(posedge sq_cs_n) begin
      int exp_edges;
      logic [15:0] exp_op;
      if (rst_n) begin
         exp_edges = m_cmd_bits / m_w + ((m_w > 1) ? 1 : 0) + 8 / m_w;
         exp_op    = (m_cmd_bits == 16) ? m_op : {8'h00, m_op[7:0]};
         chk(cap == exp_op, "R3 R4", "opcode bits on lanes", cap, exp_op);
         chk(edge_cnt == exp_edges, "R6", "serial clocks in frame", edge_cnt, exp_edges);
         chk(!oe_bad, "R5", "output enable pattern", oe_bad, 0);
         frame_idx++;
      end
   end

   // chip-select gap monitor
   int hi_cnt = 0;
   bit prev_cs = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (sq_cs_n) begin
            hi_cnt++;
         end else begin
            if (prev_cs && frame_idx > 0)
               chk(hi_cnt == GAP, "R7", "chip select high between frames", hi_cnt, GAP);
            hi_cnt = 0;
         end
         if (sq_cs_n && sq_sck) chk(1'b0, "R7", "serial clock high while deselected", 1, 0);
         prev_cs = sq_cs_n;
      end
   end

   // scoreboard monitor
   bit prev_done = 1'b0;
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (prev_done) begin
            chk(1'b0, "R9", "done wider than one cycle", 2, 1);
         end else if (sb.size() == 0) begin
            chk(1'b0, "R10", "done without a pending poll", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(frame_idx == e.frames, "R8 R9", "frames before done", frame_idx, e.frames);
            chk(m_op == e.op, "R9", "scoreboard opcode", m_op, e.op);
         end
      end
      prev_done = done;
   end

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic write_cfg(input logic [31:0] w);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic do_poll(input logic [1:0] lanes, input logic [1:0] len, input bit pos,
                          input logic [15:0] op, input int nbusy, input bit poke);
      int n;
      write_cfg({11'd0, pos, lanes, len, op});
      m_w        = (lanes == 2'b00) ? 1 : (lanes == 2'b01) ? 2 : 4;
      m_cmd_bits = (len == 2'b10) ? 16 : 8;
      m_pos      = pos;
      m_busy     = nbusy;
      m_op       = op;
      frame_idx  = 0;
      sb.push_back('{op: op, frames: nbusy + 1});
      pulse_start();
      chk(polling, "R10", "polling after accepted start", polling, 1);
      if (poke) begin
         repeat (30) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (sb.size() != 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      chk(sb.size() == 0, "R9", "poll completed", sb.size(), 0);
      chk(!cfg_err, "R2", "error clear after accepted start", cfg_err, 0);
      n = cs_falls;
      repeat (40) @(negedge clk);
      chk(cs_falls == n && !polling, "R9 R10", "no frame after done", cs_falls - n, 0);
   endtask

   initial begin
      int f0;
      repeat (5) @(negedge clk);
      chk(sq_cs_n == 1'b1 && sq_sck == 1'b0, "R7", "reset bus idle", {sq_cs_n, sq_sck}, 2'b10);
      chk(sq_oe == 4'h0, "R5", "reset output enables", sq_oe, 0);
      chk(!done && !cfg_err && !polling, "R9", "reset strobes", {done, cfg_err, polling}, 0);
      chk(cfg_rdata == 32'h0, "R1", "reset config", cfg_rdata, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      write_cfg(32'hFFFF_FFFF);
      chk(cfg_rdata == 32'h001F_FFFF, "R1", "unused bits read zero", cfg_rdata, 32'h001F_FFFF);
      write_cfg(32'h0012_3456);
      chk(cfg_rdata == 32'h0012_3456, "R1", "field readback", cfg_rdata, 32'h0012_3456);

      write_cfg(32'h0);
      f0 = cs_falls;
      pulse_start();
      repeat (40) @(negedge clk);
      chk(cfg_err && cs_falls == f0, "R2", "zero config refused", {cfg_err, 8'(cs_falls - f0)}, 9'h100);
      write_cfg(32'h000D_0005);
      pulse_start();
      repeat (40) @(negedge clk);
      chk(cfg_err && cs_falls == f0 && !polling, "R2", "reserved lane code refused",
          {cfg_err, 8'(cs_falls - f0)}, 9'h100);
      write_cfg(32'h0013_0005);
      pulse_start();
      repeat (40) @(negedge clk);
      chk(cfg_err && cs_falls == f0, "R2", "reserved length code refused",
          {cfg_err, 8'(cs_falls - f0)}, 9'h100);

      do_poll(2'b00, 2'b01, 1'b1, 16'h1205, 2, 1'b0);   // R4 single lane, R8 bit 7
      do_poll(2'b01, 2'b10, 1'b0, 16'hA55A, 1, 1'b0);   // R3 two bytes, R8 bit 0
      do_poll(2'b10, 2'b10, 1'b1, 16'hC3E1, 0, 1'b0);   // R4 quad lane
      do_poll(2'b10, 2'b01, 1'b0, 16'hFF70, 3, 1'b1);   // R10 start during polling
      do_poll(2'b01, 2'b01, 1'b1, 16'h009F, 0, 1'b0);   // R6 dual turnaround
      do_poll(2'b00, 2'b10, 1'b0, 16'h8E31, 1, 1'b1);   // R3 single lane two bytes

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule